// File: doc/BRIEF.md
# Double-Buffered Capture Channel Register Bank

This block holds the buffer and control settings for a four-channel camera-stream DMA writer. Software programs each channel through a 32-bit register port. Start address, line stride and buffer length are written into shadow registers, in units of 16 bytes. A write to the low word of the start address is the commit. It copies the shadow set and the control word into a pending slot as one unit. The pending slot moves into the active set as soon as the channel is between frames. If the channel is inside a frame, the move waits for the next frame start.

The DMA engine reads the active set from the outputs. It reports frame boundaries with one-cycle frame-start and frame-end pulses for each channel. The block tracks whether each channel is armed and whether a frame is in progress. A control word with the force bit set and the enable bit clear stops a channel in the middle of a frame, but only once it has been committed. Frame size and compression control are plain registers that drive the engine directly.

Top module: `capbuf_regs`

## Requirements
- R1: After reset, every register, every pending slot and every active set reads zero, and no channel is armed or in a frame.
- R2: Channel c owns the byte window 0x28 + 0x40*c. The word offsets within it are: +0x00 control, +0x04 low address, +0x08 stride, +0x0C length, +0x10 status, +0x14 high address, +0x18 frame size, +0x1C compression, +0x20 frame-end count. Any other address reads 0 and ignores writes, and a write reaches only the channel it addresses.
- R3: Writes to length, stride, high address and control change only the shadow values, and the active set stays as it is. Reads of address, stride and length return the shadow values.
- R4: A low-address write loads the pending slot on that clock edge. The slot holds the written low word, the shadow high address, stride, length and control. If the channel is not in a frame, the slot becomes the active set on the following edge.
- R5: While a channel is in a frame, a pending slot leaves the active set unchanged until a frame start, unless the slot is a forced stop.
- R6: A frame start with a pending slot makes the slot active on that same edge. This holds even when it coincides with a frame end. The new frame runs only if the slot's enable bit (control bit 0) is set.
- R7: A committed control word with force (bit 3) set and enable (bit 0) clear ends the frame in progress on the edge after the commit. Writing that control word alone has no effect on the running frame.
- R8: At a frame end, a channel whose active auto-arm bit (control bit 4) is clear becomes disarmed and ignores later frame starts. With auto-arm set, the channel stays armed and starts the next frame with the same active set.
- R9: A second commit while a slot is still pending replaces it, so only the newest set ever becomes active.
- R10: The active control output carries the channel mode (control bits 2:1) as 0 while the frame-size register (height in bits 31:16, width in bits 15:0) is zero. Frame size and compression control read back as written.
- R11: The status word reads bit 0 = in frame, bit 1 = armed, bit 2 = slot pending. The frame-end count word counts the frame ends that closed a frame in progress.
- R12: A frame start begins a frame only when the channel is armed with enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| frame_start | input | 4 | Frame-start pulse, one bit per channel |
| frame_end | input | 4 | Frame-end pulse, one bit per channel |
| act_addr | output | 256 | Active 64-bit start address per channel, in 16-byte units |
| act_stride | output | 128 | Active line stride per channel, in 16-byte units |
| act_len | output | 128 | Active buffer length per channel, in 16-byte units |
| act_ctrl | output | 128 | Active control word per channel, mode masked per R10 |
| frame_size | output | 128 | Frame-size register per channel |
| comp_ctrl | output | 128 | Compression-control register per channel |
| in_frame | output | 4 | Frame in progress, one bit per channel |

## Verification
A slot that is lost or applied too early shows up on the active address, length and stride outputs. The check runs one edge after an idle commit, or on the frame-start edge when the channel is busy. A faulty in-frame or armed flag shows up on the in_frame output and the status word at the next frame start or frame end. A forced stop that is ignored leaves in_frame high one edge after the second commit. A wrong window decode shows up as a change to the active set of another channel.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned WIN_SHIFT = 6;
    localparam int unsigned WIN_BASE  = 32'h28;

    typedef enum logic [3:0] {
        W_CTRL    = 4'd0,
        W_ADDR_LO = 4'd1,
        W_STRIDE  = 4'd2,
        W_LEN     = 4'd3,
        W_STATUS  = 4'd4,
        W_ADDR_HI = 4'd5,
        W_FSIZE   = 4'd6,
        W_COMP    = 4'd7,
        W_FECNT   = 4'd8
    } word_e;

    localparam int unsigned CB_EN      = 0;
    localparam int unsigned CB_MODE_LO = 1;
    localparam int unsigned CB_MODE_HI = 2;
    localparam int unsigned CB_FORCE   = 3;
    localparam int unsigned CB_AUTO    = 4;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] stride;
        logic [WORD_W-1:0] len;
    } bufset_t;

    typedef struct packed {
        bufset_t           shadow;
        bufset_t           pend;
        logic              pend_vld;
        bufset_t           act;
        logic              in_frame;
        logic              armed;
        logic [WORD_W-1:0] fsize;
        logic [WORD_W-1:0] comp;
        logic [WORD_W-1:0] fecnt;
    } chan_st_t;

endpackage

// File: rtl/capbuf_decode.sv
module capbuf_decode
    import capbuf_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned N_CH   = 4,
    localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [CH_W-1:0]   ch,
    output word_e             widx
);
    localparam int unsigned          WIN_W  = ADDR_W - WIN_SHIFT;
    localparam logic [ADDR_W-1:0]    BASE_L = ADDR_W'(WIN_BASE);
    localparam logic [WIN_W-1:0]     NCH_L  = WIN_W'(N_CH);

    logic [ADDR_W-1:0]    rel;
    logic [WIN_W-1:0]     win;
    logic [WIN_SHIFT-3:0] word;

    always_comb begin
        rel  = addr - BASE_L;
        win  = rel[ADDR_W-1:WIN_SHIFT];
        word = rel[WIN_SHIFT-1:2];
        hit  = (addr >= BASE_L) && (win < NCH_L) &&
               (word <= 4'(W_FECNT)) && (rel[1:0] == 2'b00);
        ch   = win[CH_W-1:0];
        widx = word_e'(word);
    end

endmodule

// File: rtl/capbuf_chan.sv
module capbuf_chan
    import capbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  word_e             widx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              frame_start,
    input  logic              frame_end,
    output logic [2*WORD_W-1:0] act_addr,
    output logic [WORD_W-1:0] act_stride,
    output logic [WORD_W-1:0] act_len,
    output logic [WORD_W-1:0] act_ctrl,
    output logic [WORD_W-1:0] frame_size,
    output logic [WORD_W-1:0] comp_ctrl,
    output logic              in_frame
);
    chan_st_t st_d, st_q;
    logic     force_stop;
    logic     fe_hit;
    logic     commit;

    always_comb begin
        st_d       = st_q;
        commit     = wr_en && (widx == W_ADDR_LO);
        force_stop = st_q.pend_vld && st_q.pend.ctrl[CB_FORCE] && !st_q.pend.ctrl[CB_EN];
        fe_hit     = frame_end && st_q.in_frame;

        if (fe_hit) begin
            st_d.in_frame = 1'b0;
            st_d.fecnt    = st_q.fecnt + 1'b1;
            if (!st_q.act.ctrl[CB_AUTO]) begin
                st_d.armed = 1'b0;
            end
        end

        if (st_q.pend_vld && (!st_q.in_frame || frame_start || force_stop)) begin
            st_d.act      = st_q.pend;
            st_d.pend_vld = 1'b0;
            st_d.armed    = st_q.pend.ctrl[CB_EN];
            st_d.in_frame = frame_start && st_q.pend.ctrl[CB_EN] && !force_stop;
        end else if (frame_start && st_d.armed) begin
            st_d.in_frame = 1'b1;
        end

        if (wr_en) begin
            case (widx)
                W_CTRL:    st_d.shadow.ctrl   = wdata;
                W_STRIDE:  st_d.shadow.stride = wdata;
                W_LEN:     st_d.shadow.len    = wdata;
                W_ADDR_HI: st_d.shadow.hi     = wdata;
                W_FSIZE:   st_d.fsize         = wdata;
                W_COMP:    st_d.comp          = wdata;
                W_ADDR_LO: begin
                    st_d.shadow.lo = wdata;
                    st_d.pend      = st_q.shadow;
                    st_d.pend.lo   = wdata;
                    st_d.pend_vld  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (widx)
            W_CTRL:    rdata = st_q.shadow.ctrl;
            W_ADDR_LO: rdata = st_q.shadow.lo;
            W_STRIDE:  rdata = st_q.shadow.stride;
            W_LEN:     rdata = st_q.shadow.len;
            W_STATUS:  rdata = {29'd0, st_q.pend_vld, st_q.armed, st_q.in_frame};
            W_ADDR_HI: rdata = st_q.shadow.hi;
            W_FSIZE:   rdata = st_q.fsize;
            W_COMP:    rdata = st_q.comp;
            W_FECNT:   rdata = st_q.fecnt;
            default:   rdata = '0;
        endcase
    end

    always_comb begin
        act_addr   = {st_q.act.hi, st_q.act.lo};
        act_stride = st_q.act.stride;
        act_len    = st_q.act.len;
        act_ctrl   = st_q.act.ctrl;
        if (st_q.fsize == '0) begin
            act_ctrl[CB_MODE_HI:CB_MODE_LO] = 2'b00;
        end
        frame_size = st_q.fsize;
        comp_ctrl  = st_q.comp;
        in_frame   = st_q.in_frame;
    end

    AST_COMMIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> st_q.pend_vld) else $error("commit lost"); // R4
    AST_IDLE_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend_vld && !st_q.in_frame && !commit |=> !st_q.pend_vld) else $error("idle slot held"); // R4
    AST_MIDFRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.in_frame && !frame_start && !force_stop |=> $stable(st_q.act)) else $error("active set moved mid-frame"); // R5
    AST_FORCE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        force_stop |=> !st_q.in_frame) else $error("forced stop ignored"); // R7
    AST_NO_AUTO_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end && st_q.in_frame && !frame_start && !force_stop && !st_q.act.ctrl[CB_AUTO]
        |=> !st_q.armed) else $error("stayed armed without auto-arm"); // R8

endmodule

// File: rtl/capbuf_regs.sv
module capbuf_regs
    import capbuf_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned N_CH   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    input  logic [N_CH-1:0]          frame_start,
    input  logic [N_CH-1:0]          frame_end,
    output logic [N_CH*2*WORD_W-1:0] act_addr,
    output logic [N_CH*WORD_W-1:0]   act_stride,
    output logic [N_CH*WORD_W-1:0]   act_len,
    output logic [N_CH*WORD_W-1:0]   act_ctrl,
    output logic [N_CH*WORD_W-1:0]   frame_size,
    output logic [N_CH*WORD_W-1:0]   comp_ctrl,
    output logic [N_CH-1:0]          in_frame
);
    localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic              hit;
    logic [CH_W-1:0]   ch;
    word_e             widx;
    logic [N_CH-1:0]   wr_sel;
    logic [WORD_W-1:0] chan_rd [N_CH];

    capbuf_decode #(.ADDR_W(ADDR_W), .N_CH(N_CH)) i_decode (
        .addr (bus_addr),
        .hit  (hit),
        .ch   (ch),
        .widx (widx)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        assign wr_sel[g] = bus_we && hit && (ch == CH_W'(g));

        capbuf_chan i_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (wr_sel[g]),
            .widx        (widx),
            .wdata       (bus_wdata),
            .rdata       (chan_rd[g]),
            .frame_start (frame_start[g]),
            .frame_end   (frame_end[g]),
            .act_addr    (act_addr[g*2*WORD_W +: 2*WORD_W]),
            .act_stride  (act_stride[g*WORD_W +: WORD_W]),
            .act_len     (act_len[g*WORD_W +: WORD_W]),
            .act_ctrl    (act_ctrl[g*WORD_W +: WORD_W]),
            .frame_size  (frame_size[g*WORD_W +: WORD_W]),
            .comp_ctrl   (comp_ctrl[g*WORD_W +: WORD_W]),
            .in_frame    (in_frame[g])
        );
    end

    always_comb begin
        bus_rdata = hit ? chan_rd[ch] : '0;
    end

    AST_ONE_WRITE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)) else $error("write reached several channels"); // R2

endmodule

// File: tb/test_capbuf_regs.sv
module test_capbuf_regs;

    localparam int N = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_we = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [N-1:0]    frame_start = '0;
    logic [N-1:0]    frame_end = '0;
    logic [N*64-1:0] act_addr;
    logic [N*32-1:0] act_stride, act_len, act_ctrl, frame_size, comp_ctrl;
    logic [N-1:0]    in_frame;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    capbuf_regs i_capbuf_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_start(frame_start), .frame_end(frame_end),
        .act_addr(act_addr), .act_stride(act_stride), .act_len(act_len),
        .act_ctrl(act_ctrl), .frame_size(frame_size), .comp_ctrl(comp_ctrl),
        .in_frame(in_frame)
    );

    typedef struct {
        int          src;
        int          ch;
        logic [63:0] exp;
        string       req;
    } item_t;

    item_t sb[$];

    function automatic logic [63:0] probe(int src, int ch);
        case (src)
            0: return {32'd0, bus_rdata};
            1: return act_addr[ch*64 +: 64];
            2: return {32'd0, act_len[ch*32 +: 32]};
            3: return {32'd0, act_stride[ch*32 +: 32]};
            4: return {32'd0, act_ctrl[ch*32 +: 32]};
            default: return {63'd0, in_frame[ch]};
        endcase
    endfunction

    // monitor: compares every queued item shortly after the falling edge it was queued on
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [63:0] got;
                it  = sb.pop_front();
                got = probe(it.src, it.ch);
                total++;
                if (got !== it.exp) begin
                    bad++;
                    $display("FAIL %s src=%0d ch=%0d actual=%h expected=%h",
                             it.req, it.src, it.ch, got, it.exp);
                end
            end
        end
    end

    function automatic logic [11:0] ra(int ch, int word);
        return 12'(12'h28 + ch * 64 + word * 4);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(int src, int ch, logic [63:0] exp, string req);
        item_t it;
        it.src = src; it.ch = ch; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_exp(logic [11:0] a, logic [31:0] exp, string req);
        bus_addr = a;
        expect_out(0, 0, {32'd0, exp}, req);
        @(negedge clk);
    endtask

    task automatic pulse(int ch, bit fs, bit fe);
        frame_start[ch] = fs; frame_end[ch] = fe;
        @(negedge clk);
        frame_start[ch] = 1'b0; frame_end[ch] = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd_exp(ra(0, 0), 32'h0, "R1 ctrl");
        rd_exp(ra(0, 4), 32'h0, "R1 status");
        expect_out(1, 0, 64'h0, "R1 act_addr");
        tick(1);

        // R3 shadow writes do not reach the active set
        wr(ra(0, 3), 32'h100);
        wr(ra(0, 2), 32'h40);
        wr(ra(0, 5), 32'h1);
        tick(2);
        expect_out(2, 0, 64'h0, "R3 act_len unchanged");
        rd_exp(ra(0, 3), 32'h100, "R3 shadow length");

        // R4 commit then idle apply
        wr(ra(0, 1), 32'h1000);
        rd_exp(ra(0, 4), 32'h4, "R4 slot pending");
        expect_out(1, 0, 64'h1_0000_1000, "R4 act_addr");
        expect_out(2, 0, 64'h100, "R4 act_len");
        expect_out(3, 0, 64'h40, "R4 act_stride");
        rd_exp(ra(0, 1), 32'h1000, "R3 shadow low address");

        // R12 not armed: frame start ignored
        pulse(0, 1, 0);
        expect_out(5, 0, 64'h0, "R12 unarmed start");
        tick(1);

        // enable without auto-arm
        wr(ra(0, 0), 32'h1);
        wr(ra(0, 1), 32'h2000);
        tick(1);
        rd_exp(ra(0, 4), 32'h2, "R11 status armed");
        pulse(0, 1, 0);
        expect_out(5, 0, 64'h1, "R12 armed start");
        tick(1);

        // R5 / R9 two commits mid-frame
        wr(ra(0, 1), 32'h3000);
        wr(ra(0, 1), 32'h4000);
        tick(3);
        expect_out(1, 0, 64'h1_0000_2000, "R5 held mid-frame");
        rd_exp(ra(0, 4), 32'h7, "R11 status in frame, armed, pending");

        // R6 coincident end and start applies the newest slot
        pulse(0, 1, 1);
        expect_out(1, 0, 64'h1_0000_4000, "R9 newest slot applied");
        expect_out(5, 0, 64'h1, "R6 new frame running");
        rd_exp(ra(0, 8), 32'h1, "R11 frame-end count");

        // R8 without auto-arm
        pulse(0, 0, 1);
        rd_exp(ra(0, 4), 32'h0, "R8 disarmed at frame end");
        pulse(0, 1, 0);
        expect_out(5, 0, 64'h0, "R8 start ignored after disarm");
        tick(1);

        // R8 with auto-arm
        wr(ra(0, 0), 32'h11);
        wr(ra(0, 1), 32'h5000);
        tick(1);
        pulse(0, 1, 0);
        pulse(0, 0, 1);
        rd_exp(ra(0, 4), 32'h2, "R8 still armed with auto-arm");
        pulse(0, 1, 0);
        expect_out(5, 0, 64'h1, "R8 auto re-start");
        tick(1);

        // R7 forced stop
        wr(ra(0, 0), 32'h8);
        tick(2);
        expect_out(5, 0, 64'h1, "R7 uncommitted force no effect");
        tick(1);
        wr(ra(0, 1), 32'h0);
        wr(ra(0, 1), 32'h0);
        expect_out(5, 0, 64'h0, "R7 stopped mid-frame");
        tick(1);
        expect_out(4, 0, 64'h8, "R7 active ctrl");
        tick(1);

        // R10 mode masking by frame size
        wr(ra(0, 6), 32'h0);
        wr(ra(0, 0), 32'h5);
        wr(ra(0, 1), 32'h0);
        tick(1);
        expect_out(4, 0, 64'h1, "R10 mode masked");
        tick(1);
        wr(ra(0, 6), 32'h01E0_0280);
        expect_out(4, 0, 64'h5, "R10 mode visible");
        rd_exp(ra(0, 6), 32'h01E0_0280, "R10 frame size readback");
        wr(ra(0, 7), 32'h0203_0040);
        rd_exp(ra(0, 7), 32'h0203_0040, "R10 compression readback");

        // R2 window decode
        wr(12'h0AC, 32'hABC);
        tick(1);
        expect_out(1, 2, 64'h0000_0000_0000_0ABC, "R2 channel 2 active");
        expect_out(1, 0, 64'h1_0000_0000, "R2 channel 0 untouched");
        rd_exp(12'h024, 32'h0, "R2 below first window");
        wr(12'h10C, 32'hFFFF_FFFF);
        rd_exp(12'h10C, 32'h0, "R2 unmapped word");
        expect_out(1, 3, 64'h0, "R2 channel 3 untouched");
        tick(2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule